// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block connects a synchronous on-chip request port to one external asynchronous static RAM holding 128K bytes. A requester presents a single-cycle request with a write flag, a 17-bit byte address and 8 bits of write data. The controller runs the SRAM's pin-level read or write sequence, then raises a one-cycle completion pulse. For reads, the byte fetched from the device appears alongside that pulse.

The device has two chip selects of opposite polarity: one active low, one active high. The controller always drives them as a pair, and it parks the device in standby whenever no access is in progress. The data bus is split into an outbound value, an inbound value and a drive-enable, so the pad ring can form the bidirectional pins.

All wait states are computed from the clock period and the device speed grade:
- The read window covers the longest of the address, chip-select and output-enable access times.
- The write-enable pulse covers a configured minimum width.
- A write that follows a read waits out the device's output float time before the controller turns its own drivers on.

Top module: `asram_ctrl`

## Requirements
- R1: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle. A `req_valid` presented while busy starts no SRAM cycle, produces no `resp_done` and changes no memory content.
- R2: During and after reset, and whenever idle, the pins are parked as follows: `sram_sel_n`=1, `sram_sel`=0, `sram_oe_n`=1, `sram_we_n`=1, `sram_dq_oe`=0. After reset, `req_ready`=1, `resp_done`=0 and `resp_rdata`=0.
- R3: `sram_sel` is always the inverse of `sram_sel_n`, and the device is selected only when `sram_sel_n`=0 and `sram_sel`=1. `sram_addr` takes its new value on the same edge that selects the device and holds steady through every selected cycle.
- R4: A read holds `sram_oe_n` low and `sram_we_n` high for RD_CYC cycles. RD_CYC = ceil(max(grade, oe_access)/clock period), where oe_access is 10/20/25/35 ns for grades 35/45/55/70 ns. The data bus is sampled at the end of that window. `resp_done` and `resp_rdata` appear RD_CYC edges after the accepting edge (7 for a 35 ns grade with a 5 ns clock).
- R5: A write is one setup cycle with data driven, then `sram_we_n` low for WP_CYC = ceil(25 ns/clock period) cycles, then one hold cycle with `sram_we_n` high and data still driven. `sram_oe_n` stays high throughout. `resp_done` follows WP_CYC+2 edges after acceptance (7 with defaults), provided no turnaround wait applies.
- R6: After a read ends, `sram_dq_oe` stays low for at least FL_CYC = ceil(float/clock period) cycles, where float is 10/15/20/25 ns for grades 35/45/55/70 ns. A write accepted on the edge right after a read's `resp_done` therefore completes one edge later (8 with defaults). A write accepted two or more edges after the read completes takes 7.
- R7: `sram_dq_oe` is never high while `sram_oe_n` is low, and the controller never drives the bus while the device may still be driving it.
- R8: `resp_done` is high for exactly one cycle per completed request. `resp_rdata` changes only when a read completes; writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle and able to take a request |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 8 | Data of the most recent completed read |
| sram_addr | output | 17 | SRAM address bus |
| sram_sel_n | output | 1 | Active-low chip select |
| sram_sel | output | 1 | Active-high chip select |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_dq_out | output | 8 | Data driven toward the SRAM |
| sram_dq_oe | output | 1 | Enables the controller's data drivers |
| sram_dq_in | input | 8 | Data received from the SRAM pins |

## Verification
The hardest case to reach from the ports is a write taken on the very edge after a read completes, while the memory's outputs are still floating off the bus. The stimulus table issues every request in the half-cycle straight after the previous completion pulse, so each write that follows a read lands inside that window. The bench's memory model keeps driving garbage for the full float time after its enables drop, so any early controller drive shows up as bus contention. The model also returns garbage until every access time has elapsed, so a read sampled one cycle early returns a wrong byte.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int ADDR_W_DEF = 17;
    localparam int DATA_W_DEF = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_TURN   = 3'd2,
        ST_WSETUP = 3'd3,
        ST_WPULSE = 3'd4,
        ST_WHOLD  = 3'd5
    } asram_state_e;

    // Control pin levels presented to the device, registered as a group.
    typedef struct packed {
        logic sel_n;
        logic sel;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } asram_pins_t;

    localparam asram_pins_t PINS_PARK = '{sel_n: 1'b1, sel: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

    function automatic int ceil_div(input int t, input int p);
        return (t + p - 1) / p;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Output-enable access time for a speed grade, in ns.
    function automatic int oe_access_ns(input int grade);
        if (grade <= 35)      return 10;
        else if (grade <= 45) return 20;
        else if (grade <= 55) return 25;
        else                  return 35;
    endfunction

    // Time for device outputs to release the bus after a disable, in ns.
    function automatic int float_ns(input int grade);
        if (grade <= 35)      return 10;
        else if (grade <= 45) return 15;
        else if (grade <= 55) return 20;
        else                  return 25;
    endfunction

    function automatic asram_pins_t pins_for(input asram_state_e s);
        asram_pins_t p;
        p = PINS_PARK;
        case (s)
            ST_READ: begin
                p.sel_n = 1'b0; p.sel = 1'b1; p.oe_n = 1'b0;
            end
            ST_WSETUP, ST_WHOLD: begin
                p.sel_n = 1'b0; p.sel = 1'b1; p.dq_oe = 1'b1;
            end
            ST_WPULSE: begin
                p.sel_n = 1'b0; p.sel = 1'b1; p.dq_oe = 1'b1; p.we_n = 1'b0;
            end
            default: p = PINS_PARK;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    // High in the final cycle of a loaded interval, and while expired.
    assign last = (cnt <= W'(1));
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int CW     = 4,
    parameter int RD_CYC = 7,
    parameter int WP_CYC = 5,
    parameter int FL_CYC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_fire,
    input  logic        req_write,
    output logic        idle,
    output asram_pins_t pins,
    output logic        capture,
    output logic        finish
);
    asram_state_e state, nxt;
    logic         phase_load, phase_last;
    logic [CW-1:0] phase_val;
    logic         turn_load, turn_last;

    asram_timer #(.W(CW)) u_phase (
        .clk(clk), .rst(rst), .load(phase_load), .load_val(phase_val), .last(phase_last)
    );

    asram_timer #(.W(CW)) u_turn (
        .clk(clk), .rst(rst), .load(turn_load), .load_val(CW'(FL_CYC)), .last(turn_last)
    );

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: begin
                if (req_fire) begin
                    if (!req_write)     nxt = ST_READ;
                    else if (turn_last) nxt = ST_WSETUP;
                    else                nxt = ST_TURN;
                end
            end
            ST_READ:   if (phase_last) nxt = ST_IDLE;
            ST_TURN:   if (turn_last)  nxt = ST_WSETUP;
            ST_WSETUP: nxt = ST_WPULSE;
            ST_WPULSE: if (phase_last) nxt = ST_WHOLD;
            ST_WHOLD:  nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    assign phase_load = ((nxt == ST_READ) && (state != ST_READ)) ||
                        ((nxt == ST_WPULSE) && (state != ST_WPULSE));
    assign phase_val  = (nxt == ST_READ) ? CW'(RD_CYC) : CW'(WP_CYC);
    assign capture    = (state == ST_READ) && phase_last;
    assign turn_load  = capture;
    assign finish     = capture || (state == ST_WHOLD);
    assign idle       = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pins  <= PINS_PARK;
        end else begin
            state <= nxt;
            pins  <= pins_for(nxt);
        end
    end
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          capture,
    input  logic          finish,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] dq_out,
    output logic [DW-1:0] rdata,
    output logic          done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sram_addr <= '0;
            dq_out    <= '0;
            rdata     <= '0;
            done      <= 1'b0;
        end else begin
            if (accept) begin
                sram_addr <= req_addr;
                dq_out    <= req_wdata;
            end
            if (capture) rdata <= dq_in;
            done <= finish;
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int DATA_W   = DATA_W_DEF,
    parameter int CLK_NS   = 5,
    parameter int GRADE_NS = 35,
    parameter int WP_NS    = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              resp_done,
    output logic [DATA_W-1:0] resp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_sel_n,
    output logic              sram_sel,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    // Address and chip-select access equal the grade; OE access is shorter or equal.
    localparam int RD_CYC = ceil_div(max_of(GRADE_NS, oe_access_ns(GRADE_NS)), CLK_NS);
    localparam int WP_CYC = ceil_div(WP_NS, CLK_NS);
    localparam int FL_CYC = ceil_div(float_ns(GRADE_NS), CLK_NS);
    localparam int MAX_CYC = max_of(max_of(RD_CYC, WP_CYC), FL_CYC);
    localparam int CW     = $clog2(MAX_CYC + 1);

    logic        idle, capture, finish, req_fire;
    asram_pins_t pins;

    assign req_ready = idle;
    assign req_fire  = req_valid && idle;

    asram_seq #(
        .CW(CW), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .FL_CYC(FL_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .req_fire(req_fire), .req_write(req_write),
        .idle(idle), .pins(pins), .capture(capture), .finish(finish)
    );

    asram_datapath #(.AW(ADDR_W), .DW(DATA_W)) u_dp (
        .clk(clk), .rst(rst), .accept(req_fire), .req_addr(req_addr),
        .req_wdata(req_wdata), .capture(capture), .finish(finish),
        .dq_in(sram_dq_in), .sram_addr(sram_addr), .dq_out(sram_dq_out),
        .rdata(resp_rdata), .done(resp_done)
    );

    assign sram_sel_n = pins.sel_n;
    assign sram_sel   = pins.sel;
    assign sram_oe_n  = pins.oe_n;
    assign sram_we_n  = pins.we_n;
    assign sram_dq_oe = pins.dq_oe;
endmodule

// File: rtl/asram_ctrl_checker.sv
module asram_ctrl_checker
    import asram_pkg::*;
#(
    parameter int CLK_NS   = 5,
    parameter int GRADE_NS = 35,
    parameter int AW       = 17
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          resp_done,
    input logic          sram_sel_n,
    input logic          sram_sel,
    input logic          sram_oe_n,
    input logic          sram_we_n,
    input logic          sram_dq_oe,
    input logic [AW-1:0] sram_addr
);
    localparam int RD_CYC = ceil_div(max_of(GRADE_NS, oe_access_ns(GRADE_NS)), CLK_NS);
    localparam int FL_CYC = ceil_div(float_ns(GRADE_NS), CLK_NS);
    localparam int KW     = $clog2(max_of(RD_CYC, FL_CYC) + 2);

    logic [KW-1:0] off_cnt;  // cycles since output enable was last low, saturating
    logic [KW-1:0] low_cnt;  // length of the current output-enable low window

    always_ff @(posedge clk) begin
        if (rst) begin
            off_cnt <= KW'(FL_CYC);
            low_cnt <= '0;
        end else begin
            if (!sram_oe_n)                 off_cnt <= '0;
            else if (off_cnt < KW'(FL_CYC)) off_cnt <= off_cnt + 1'b1;
            if (sram_oe_n)                  low_cnt <= '0;
            else if (low_cnt != '1)         low_cnt <= low_cnt + 1'b1;
        end
    end

    assert_idle_pins_R2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (sram_sel_n && !sram_sel && sram_oe_n && sram_we_n && !sram_dq_oe));

    assert_enable_polarity_R3: assert property (@(posedge clk) disable iff (rst)
        sram_sel == !sram_sel_n);

    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (!sram_sel_n && $past(!sram_sel_n)) |-> $stable(sram_addr));

    assert_read_window_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_oe_n) |-> (low_cnt == KW'(RD_CYC)));

    assert_we_high_in_read_R4: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> sram_we_n);

    assert_write_drive_R5: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (sram_dq_oe && !sram_sel_n && sram_oe_n));

    assert_write_hold_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> sram_dq_oe);

    assert_turnaround_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_dq_oe) |-> (off_cnt >= KW'(FL_CYC)));

    assert_no_drive_in_read_R7: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> !sram_dq_oe);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        resp_done |=> !resp_done);
endmodule

bind asram_ctrl asram_ctrl_checker #(
    .CLK_NS(CLK_NS), .GRADE_NS(GRADE_NS), .AW(ADDR_W)
) u_check (
    .clk(clk), .rst(rst), .req_ready(req_ready), .resp_done(resp_done),
    .sram_sel_n(sram_sel_n), .sram_sel(sram_sel), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_dq_oe(sram_dq_oe), .sram_addr(sram_addr)
);

// File: tb/tb_asram_ctrl.sv
`timescale 1ns/1ps
module tb_asram_ctrl;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int RD_LAT = 7;        // R4: 35 ns grade, 5 ns clock
    localparam int WP_LEN = 5;        // R5: 25 ns / 5 ns
    localparam int WR_LAT = WP_LEN + 2;
    localparam real T_ACC   = 35.0;
    localparam real T_OEACC = 10.0;
    localparam real T_FLOAT = 10.0;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, resp_done, sram_sel_n, sram_sel, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [DW-1:0] resp_rdata, sram_dq_out, sram_dq_in;
    logic [AW-1:0] sram_addr;

    asram_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_done(resp_done), .resp_rdata(resp_rdata), .sram_addr(sram_addr),
        .sram_sel_n(sram_sel_n), .sram_sel(sram_sel), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_dq_in(sram_dq_in)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural memory with tri-state output ----------------
    logic [7:0] mem [int];
    bit   rst_seen = 1'b0;
    real  t_addr = -1000.0, t_sel = -1000.0, t_oe = -1000.0, t_off = -1000.0;
    logic m_drive = 1'b0;
    logic [7:0] m_data = 8'hEE;
    int   contention = 0;

    always @(sram_addr)        t_addr = $realtime;
    always @(negedge sram_sel_n) t_sel = $realtime;
    always @(posedge sram_sel_n) t_off = $realtime;
    always @(negedge sram_oe_n)  t_oe  = $realtime;
    always @(posedge sram_oe_n)  t_off = $realtime;

    always @(posedge sram_we_n)
        if (rst_seen && !sram_sel_n && sram_sel && sram_dq_oe)
            mem[int'(sram_addr)] = sram_dq_out;

    function automatic logic [7:0] mem_rd(input int a);
        return mem.exists(a) ? mem[a] : 8'h5A;
    endfunction

    initial begin
        #0.25;
        forever begin
            real now;
            now = $realtime;
            if (!sram_sel_n && sram_sel && !sram_oe_n && sram_we_n) begin
                m_drive = 1'b1;
                if ((now - t_addr >= T_ACC - 0.5) && (now - t_sel >= T_ACC - 0.5) &&
                    (now - t_oe >= T_OEACC - 0.5))
                    m_data = mem_rd(int'(sram_addr));
                else
                    m_data = 8'hEE;
            end else if (m_drive && (now - t_off < T_FLOAT)) begin
                m_data = 8'hEE;
            end else begin
                m_drive = 1'b0;
            end
            if (rst_seen && m_drive && sram_dq_oe) contention++;
            #0.5;
        end
    end

    assign sram_dq_in = m_drive ? m_data : (sram_dq_oe ? sram_dq_out : 8'h00);

    // ---------------- pin monitors at the falling edge ----------------
    int done_cnt = 0, pol_bad = 0, we_in_rd = 0, done_wide = 0, we_run = 0;
    logic prev_we = 1'b1, prev_done = 1'b0;
    always @(negedge clk) if (rst_seen) begin
        if (resp_done) done_cnt++;
        if (prev_done && resp_done) done_wide++;
        if (sram_sel != !sram_sel_n) pol_bad++;
        if (!sram_oe_n && !sram_we_n) we_in_rd++;
        if (!sram_we_n) we_run++;
        if (!prev_we && sram_we_n) begin
            chk("R5 write pulse length", we_run, WP_LEN);
            chk("R5 data held after write enable rises", int'(sram_dq_oe), 1);
            we_run = 0;
        end
        prev_we   = sram_we_n;
        prev_done = resp_done;
    end

    // ---------------- request task: called and returns at a falling edge ----------------
    task automatic run_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           output int lat, output logic [DW-1:0] rd);
        chk("R1 ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!resp_done && lat < 200) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        rd = resp_rdata;
    endtask

    // {write, address, write data, expected read data}
    localparam logic [33:0] VEC [16] = '{
        {1'b1, 17'h00000, 8'hA5, 8'h00},
        {1'b1, 17'h1FFFF, 8'h3C, 8'h00},
        {1'b1, 17'h0A5A5, 8'hE1, 8'h00},
        {1'b1, 17'h15C3A, 8'h7F, 8'h00},
        {1'b0, 17'h00000, 8'h00, 8'hA5},
        {1'b0, 17'h1FFFF, 8'h00, 8'h3C},
        {1'b1, 17'h0A5A5, 8'h18, 8'h00},
        {1'b0, 17'h0A5A5, 8'h00, 8'h18},
        {1'b0, 17'h15C3A, 8'h00, 8'h7F},
        {1'b1, 17'h00001, 8'h00, 8'h00},
        {1'b0, 17'h00001, 8'h00, 8'h00},
        {1'b1, 17'h10000, 8'hFF, 8'h00},
        {1'b0, 17'h10000, 8'h00, 8'hFF},
        {1'b0, 17'h0A5A6, 8'h00, 8'h5A},
        {1'b1, 17'h03217, 8'h96, 8'h00},
        {1'b0, 17'h03217, 8'h00, 8'h96}
    };

    initial begin
        int lat, base;
        logic [DW-1:0] rd, last_rd;
        bit prev_read;

        repeat (3) @(negedge clk);
        chk("R2 reset sel_n", int'(sram_sel_n), 1);
        chk("R2 reset sel", int'(sram_sel), 0);
        chk("R2 reset oe_n", int'(sram_oe_n), 1);
        chk("R2 reset we_n", int'(sram_we_n), 1);
        chk("R2 reset dq_oe", int'(sram_dq_oe), 0);
        chk("R2 reset done", int'(resp_done), 0);
        chk("R2 reset rdata", int'(resp_rdata), 0);
        rst = 1'b0;
        rst_seen = 1'b1;
        @(negedge clk);
        chk("R2 ready after reset", int'(req_ready), 1);

        prev_read = 1'b0;
        last_rd   = '0;
        for (int i = 0; i < 16; i++) begin
            bit wr;
            logic [AW-1:0] a;
            logic [DW-1:0] d, e;
            {wr, a, d, e} = VEC[i];
            run_req(wr, a, d, lat, rd);
            if (wr) begin
                chk(prev_read ? "R6 write latency after read" : "R5 write latency",
                    lat, prev_read ? WR_LAT + 1 : WR_LAT);
                chk("R8 rdata unchanged by write", int'(rd), int'(last_rd));
            end else begin
                chk("R4 read latency", lat, RD_LAT);
                chk("R4 read data", int'(rd), int'(e));
                last_rd = e;
            end
            prev_read = !wr;
        end

        // R6 boundary: write accepted two edges after a read completes needs no extra wait
        run_req(1'b0, 17'h00000, 8'h00, lat, rd);
        chk("R4 read data before gap", int'(rd), 8'hA5);
        @(negedge clk);
        run_req(1'b1, 17'h0ABCD, 8'h42, lat, rd);
        chk("R6 write latency after idle gap", lat, WR_LAT);

        // R1: a request presented while busy is ignored
        @(negedge clk);
        base = done_cnt;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h1FFFF;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R1 not ready while busy", int'(req_ready), 0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h1FFFF; req_wdata = 8'h00;
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_done) @(negedge clk);
        chk("R1 read data with intruding request", int'(resp_rdata), 8'h3C);
        repeat (12) @(negedge clk);
        chk("R1 one completion only", done_cnt - base, 1);
        chk("R2 idle sel_n", int'(sram_sel_n), 1);
        chk("R2 idle dq_oe", int'(sram_dq_oe), 0);
        run_req(1'b0, 17'h1FFFF, 8'h00, lat, rd);
        chk("R1 ignored write left memory", int'(rd), 8'h3C);
        run_req(1'b0, 17'h0ABCD, 8'h00, lat, rd);
        chk("R4 read back after gap write", int'(rd), 8'h42);

        repeat (4) @(negedge clk);
        chk("R7 bus contention events", contention, 0);
        chk("R3 enable polarity violations", pol_bad, 0);
        chk("R4 write enable low during read", we_in_rd, 0);
        chk("R8 done wider than one cycle", done_wide, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule